// File: doc/BRIEF.md
# Synthesizer Counter Programming Interface

This block is the configuration front end of an integer-N frequency synthesizer. It holds the 20-bit primary word that sets the main divider count M (9 bits), the swallow count A (4 bits), the reference count R (6 bits) and a prescaler-bypass bit. It also holds an 8-bit enhancement word. A hop strobe copies the primary word into a secondary word. A select input then chooses which of the two words drives the counter outputs, so a new frequency can be staged while the old one is still in use.

Three loading modes exist, chosen by two mode pins. The first is a serial shift port. The second is a byte-wide parallel bus with three field strobes that scatter byte bits into non-contiguous fields. The third is a direct mode in which the M and A counts and the active-low prescaler enable come straight from pins. All strobes, the shift clock and the level inputs are brought into one system clock through synchronizers, and only the rising edges of strobes and of the shift clock take effect.

Top module: `synth_cfg_front`

## Requirements
- R1: After reset, the primary, secondary and enhancement words are zero, primary is the selected source, and every output reads zero.
- R2: When `mode_direct` is 1, whatever the value of `mode_serial`, `m_cnt` follows `dir_m`, `a_cnt` follows `dir_a`, `presc_bypass` follows `dir_presc_n`, and `r_cnt` reads zero. `mode_direct`=0 with `mode_serial`=1 selects serial mode. Both at 0 select parallel mode.
- R3: In serial mode with `enh_wr` low, each rising edge of `sh_clk` shifts `sh_data` into bit 0 of the primary word, MSB first. The word is packed as bypass at bit 19, M at bits 18:10, R at bits 9:4 and A at bits 3:0.
- R4: In serial mode with `enh_wr` high, each rising `sh_clk` edge shifts `sh_data` into the enhancement word MSB first, and the primary word is unchanged.
- R5: In parallel mode, a rising edge on `stb_m_lo` loads `pbus[7]` into the bypass bit and `pbus[6:0]` into M[6:0]. All other bits are unchanged.
- R6: In parallel mode, a rising edge on `stb_m_hi` loads `pbus[3]` into R[5], `pbus[2]` into R[4], `pbus[1]` into M[8] and `pbus[0]` into M[7]. All other bits are unchanged.
- R7: In parallel mode, a rising edge on `stb_ar` loads `pbus[7:4]` into R[3:0] and `pbus[3:0]` into A[3:0].
- R8: In parallel mode, a rising edge on `enh_wr` loads `pbus` into the enhancement word.
- R9: In serial or parallel mode, a rising edge on `hop_stb` copies the primary word into the secondary word. The secondary word keeps that value when the primary word changes later.
- R10: A select value of 1 shows the primary word on the outputs and 0 shows the secondary word. `sel_pri_ser` is the select in serial mode, `sel_pri_par` is the select in parallel mode, and the other select has no effect.
- R11: Parallel strobes have no effect in serial mode. `sh_clk` edges have no effect in parallel mode. In direct mode, no word changes, and this includes the hop strobe.
- R12: A strobe held high acts once, on its rising edge. Bus changes while the strobe stays high are not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | 1 selects direct mode |
| mode_serial | input | 1 | With mode_direct at 0: 1 serial, 0 parallel |
| sh_clk | input | 1 | Serial shift clock, acts on its rising edge |
| sh_data | input | 1 | Serial data, MSB first |
| enh_wr | input | 1 | Serial: target is the enhancement word. Parallel: enhancement load strobe |
| pbus | input | 8 | Parallel data byte |
| stb_m_lo | input | 1 | Strobe for the bypass bit and M[6:0] |
| stb_m_hi | input | 1 | Strobe for R[5:4] and M[8:7] |
| stb_ar | input | 1 | Strobe for R[3:0] and A[3:0] |
| hop_stb | input | 1 | Copies the primary word into the secondary word |
| sel_pri_ser | input | 1 | Source select in serial mode (1 = primary) |
| sel_pri_par | input | 1 | Source select in parallel mode (1 = primary) |
| dir_m | input | 9 | M count in direct mode |
| dir_a | input | 4 | A count in direct mode |
| dir_presc_n | input | 1 | Active-low prescaler enable in direct mode |
| m_cnt | output | 9 | M count to the counters |
| a_cnt | output | 4 | A count to the counters |
| r_cnt | output | 6 | R count to the counters |
| presc_bypass | output | 1 | 1 = the input bypasses the prescaler |
| enh_word | output | 8 | Enhancement word |

## Verification
A misplaced scatter bit or a wrong shift order shows up on the count outputs about three clocks after the strobe or shift edge, once the synchronizers have passed it. A corrupt secondary word stays hidden while primary is selected. The bench therefore flips the select pin after every hop and checks both words. Strobes that leak across modes appear only as a changed word some time later, so each such stimulus is followed by a read of every output before the next change.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int unsigned M_W   = 9;
  localparam int unsigned A_W   = 4;
  localparam int unsigned R_W   = 6;
  localparam int unsigned ENH_W = 8;
  localparam int unsigned BUS_W = 8;

  localparam int unsigned PRI_W   = 1 + M_W + R_W + A_W;
  localparam int unsigned A_LSB   = 0;
  localparam int unsigned R_LSB   = A_LSB + A_W;
  localparam int unsigned M_LSB   = R_LSB + R_W;
  localparam int unsigned BYP_BIT = PRI_W - 1;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } cfg_mode_e;

  function automatic cfg_mode_e decode_mode(input logic dir_pin, input logic ser_pin);
    if (dir_pin)      return MODE_DIR;
    else if (ser_pin) return MODE_SER;
    else              return MODE_PAR;
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        pipe_q[i] <= RST_VAL;
      end
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/scfg_rise.sv
module scfg_rise #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  for (genvar g = 0; g < W; g++) begin : g_chk
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]) else $error("strobe pulse longer than one cycle"); // R12
  end

endmodule

// File: rtl/scfg_serial.sv
module scfg_serial
  import synth_cfg_pkg::*;
(
  input  logic [PRI_W-1:0] pri_q,
  input  logic [ENH_W-1:0] enh_q,
  input  logic             shift,
  input  logic             to_enh,
  input  logic             bit_in,
  output logic [PRI_W-1:0] pri_nxt,
  output logic             pri_we,
  output logic [ENH_W-1:0] enh_nxt,
  output logic             enh_we
);

  always_comb begin
    pri_nxt = {pri_q[PRI_W-2:0], bit_in};
    enh_nxt = {enh_q[ENH_W-2:0], bit_in};
    pri_we  = shift && !to_enh;
    enh_we  = shift &&  to_enh;
  end

endmodule

// File: rtl/scfg_parallel.sv
module scfg_parallel
  import synth_cfg_pkg::*;
(
  input  logic [PRI_W-1:0] pri_q,
  input  logic [BUS_W-1:0] bus,
  input  logic             stb_lo,
  input  logic             stb_hi,
  input  logic             stb_ar,
  input  logic             stb_enh,
  output logic [PRI_W-1:0] pri_nxt,
  output logic             pri_we,
  output logic [ENH_W-1:0] enh_nxt,
  output logic             enh_we
);

  always_comb begin
    pri_nxt = pri_q;
    if (stb_lo) begin
      pri_nxt[BYP_BIT]      = bus[7];
      pri_nxt[M_LSB +: 7]   = bus[6:0];
    end
    if (stb_hi) begin
      pri_nxt[R_LSB + 5]    = bus[3];
      pri_nxt[R_LSB + 4]    = bus[2];
      pri_nxt[M_LSB + 8]    = bus[1];
      pri_nxt[M_LSB + 7]    = bus[0];
    end
    if (stb_ar) begin
      pri_nxt[R_LSB +: 4]   = bus[7:4];
      pri_nxt[A_LSB +: A_W] = bus[3:0];
    end
    pri_we  = stb_lo || stb_hi || stb_ar;
    enh_nxt = bus;
    enh_we  = stb_enh;
  end

endmodule

// File: rtl/synth_cfg_front.sv
module synth_cfg_front
  import synth_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_direct,
  input  logic             mode_serial,
  input  logic             sh_clk,
  input  logic             sh_data,
  input  logic             enh_wr,
  input  logic [BUS_W-1:0] pbus,
  input  logic             stb_m_lo,
  input  logic             stb_m_hi,
  input  logic             stb_ar,
  input  logic             hop_stb,
  input  logic             sel_pri_ser,
  input  logic             sel_pri_par,
  input  logic [M_W-1:0]   dir_m,
  input  logic [A_W-1:0]   dir_a,
  input  logic             dir_presc_n,
  output logic [M_W-1:0]   m_cnt,
  output logic [A_W-1:0]   a_cnt,
  output logic [R_W-1:0]   r_cnt,
  output logic             presc_bypass,
  output logic [ENH_W-1:0] enh_word
);

  localparam int unsigned NEDGE  = 6;
  localparam int unsigned E_SCLK = 0;
  localparam int unsigned E_ENH  = 1;
  localparam int unsigned E_MLO  = 2;
  localparam int unsigned E_MHI  = 3;
  localparam int unsigned E_AR   = 4;
  localparam int unsigned E_HOP  = 5;
  localparam int unsigned CTL_W  = NEDGE + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // synchronizers
  logic [CTL_W-1:0] ctl_lvl;
  logic [NEDGE-1:0] ctl_rise;
  logic [1:0]       mode_lvl;
  logic [1:0]       sel_lvl;
  logic [BUS_W-1:0] bus_lvl;

  scfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ctl_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({sh_data, hop_stb, stb_ar, stb_m_hi, stb_m_lo, enh_wr, sh_clk}),
    .q(ctl_lvl)
  );

  scfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_mode_sync (
    .clk(clk), .rst_n(rst_ni), .d({mode_direct, mode_serial}), .q(mode_lvl)
  );

  scfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sel_sync (
    .clk(clk), .rst_n(rst_ni), .d({sel_pri_ser, sel_pri_par}), .q(sel_lvl)
  );

  scfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_ni), .d(pbus), .q(bus_lvl)
  );

  scfg_rise #(.W(NEDGE)) u_rise (
    .clk(clk), .rst_n(rst_ni), .lvl(ctl_lvl[NEDGE-1:0]), .rise(ctl_rise)
  );

  cfg_mode_e mode_now;
  logic      enh_lvl;
  logic      sh_bit;

  assign mode_now = decode_mode(mode_lvl[1], mode_lvl[0]);
  assign enh_lvl  = ctl_lvl[E_ENH];
  assign sh_bit   = ctl_lvl[CTL_W-1];

  // state
  logic [PRI_W-1:0] pri_q, pri_d, sec_q;
  logic [ENH_W-1:0] enh_q, enh_d;
  logic             pri_en, enh_en, hop_en;

  logic [PRI_W-1:0] ser_pri, par_pri;
  logic [ENH_W-1:0] ser_enh, par_enh;
  logic             ser_pri_we, ser_enh_we, par_pri_we, par_enh_we;

  scfg_serial u_serial (
    .pri_q(pri_q), .enh_q(enh_q),
    .shift(ctl_rise[E_SCLK]), .to_enh(enh_lvl), .bit_in(sh_bit),
    .pri_nxt(ser_pri), .pri_we(ser_pri_we),
    .enh_nxt(ser_enh), .enh_we(ser_enh_we)
  );

  scfg_parallel u_parallel (
    .pri_q(pri_q), .bus(bus_lvl),
    .stb_lo(ctl_rise[E_MLO]), .stb_hi(ctl_rise[E_MHI]),
    .stb_ar(ctl_rise[E_AR]), .stb_enh(ctl_rise[E_ENH]),
    .pri_nxt(par_pri), .pri_we(par_pri_we),
    .enh_nxt(par_enh), .enh_we(par_enh_we)
  );

  // next state
  always_comb begin
    pri_d  = pri_q;
    enh_d  = enh_q;
    pri_en = 1'b0;
    enh_en = 1'b0;
    hop_en = 1'b0;
    case (mode_now)
      MODE_SER: begin
        pri_d  = ser_pri;
        pri_en = ser_pri_we;
        enh_d  = ser_enh;
        enh_en = ser_enh_we;
        hop_en = ctl_rise[E_HOP];
      end
      MODE_PAR: begin
        pri_d  = par_pri;
        pri_en = par_pri_we;
        enh_d  = par_enh;
        enh_en = par_enh_we;
        hop_en = ctl_rise[E_HOP];
      end
      default: begin
        hop_en = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pri_q <= '0;
    else if (pri_en) pri_q <= pri_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= '0;
    else if (hop_en) sec_q <= pri_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     enh_q <= '0;
    else if (enh_en) enh_q <= enh_d;
  end

  // output selection
  logic             sel_pri;
  logic [PRI_W-1:0] view;

  assign sel_pri = (mode_now == MODE_SER) ? sel_lvl[1] : sel_lvl[0];
  assign view    = sel_pri ? pri_q : sec_q;

  always_comb begin
    if (mode_now == MODE_DIR) begin
      m_cnt        = dir_m;
      a_cnt        = dir_a;
      r_cnt        = '0;
      presc_bypass = dir_presc_n;
    end else begin
      m_cnt        = view[M_LSB +: M_W];
      a_cnt        = view[A_LSB +: A_W];
      r_cnt        = view[R_LSB +: R_W];
      presc_bypass = view[BYP_BIT];
    end
  end

  assign enh_word = enh_q;

  // assertions
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_now == MODE_SER && ctl_rise[E_SCLK] && !enh_lvl)
      |=> (pri_q == {$past(pri_q[PRI_W-2:0]), $past(sh_bit)}))
    else $error("serial shift into primary wrong"); // R3

  AST_ENH_KEEPS_PRI: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_now == MODE_SER && ctl_rise[E_SCLK] && enh_lvl) |=> $stable(pri_q))
    else $error("primary moved during enhancement shift"); // R4

  AST_PAR_ENH: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_now == MODE_PAR && ctl_rise[E_ENH]) |=> (enh_q == $past(bus_lvl)))
    else $error("enhancement byte not loaded"); // R8

  AST_HOP_COPY: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_now != MODE_DIR && ctl_rise[E_HOP]) |=> (sec_q == $past(pri_q)))
    else $error("hop did not copy primary"); // R9

  AST_DIR_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_now == MODE_DIR) |=> ($stable(pri_q) && $stable(sec_q) && $stable(enh_q)))
    else $error("word changed in direct mode"); // R11

endmodule

// File: tb/test_synth_cfg_front.sv
`timescale 1ns/1ps
module test_synth_cfg_front;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_direct, mode_serial;
  logic       sh_clk, sh_data, enh_wr;
  logic [7:0] pbus;
  logic       stb_m_lo, stb_m_hi, stb_ar, hop_stb;
  logic       sel_pri_ser, sel_pri_par;
  logic [8:0] dir_m;
  logic [3:0] dir_a;
  logic       dir_presc_n;
  logic [8:0] m_cnt;
  logic [3:0] a_cnt;
  logic [5:0] r_cnt;
  logic       presc_bypass;
  logic [7:0] enh_word;

  always #2.5 clk = ~clk;

  synth_cfg_front i_synth_cfg_front (
    .clk(clk), .rst_n(rst_n),
    .mode_direct(mode_direct), .mode_serial(mode_serial),
    .sh_clk(sh_clk), .sh_data(sh_data), .enh_wr(enh_wr),
    .pbus(pbus), .stb_m_lo(stb_m_lo), .stb_m_hi(stb_m_hi), .stb_ar(stb_ar),
    .hop_stb(hop_stb), .sel_pri_ser(sel_pri_ser), .sel_pri_par(sel_pri_par),
    .dir_m(dir_m), .dir_a(dir_a), .dir_presc_n(dir_presc_n),
    .m_cnt(m_cnt), .a_cnt(a_cnt), .r_cnt(r_cnt),
    .presc_bypass(presc_bypass), .enh_word(enh_word)
  );

  typedef struct {
    string      tag;
    logic [8:0] m;
    logic [3:0] a;
    logic [5:0] r;
    logic       byp;
    logic [7:0] enh;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // bench model of the words
  logic [19:0] b_pri, b_sec;
  logic [7:0]  b_enh;

  // monitor: pops and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({m_cnt, a_cnt, r_cnt, presc_bypass, enh_word} !== {e.m, e.a, e.r, e.byp, e.enh}) begin
        errors++;
        $display("FAIL %s: got m=%h a=%h r=%h byp=%b enh=%h expected m=%h a=%h r=%h byp=%b enh=%h",
                 e.tag, m_cnt, a_cnt, r_cnt, presc_bypass, enh_word, e.m, e.a, e.r, e.byp, e.enh);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input string tag, input logic [8:0] m, input logic [3:0] a,
                          input logic [5:0] r, input logic byp, input logic [7:0] e);
    exp_t x;
    cyc(5);
    @(posedge clk);
    #1;
    x.tag = tag; x.m = m; x.a = a; x.r = r; x.byp = byp; x.enh = e;
    q.push_back(x);
    wait (q.size() == 0);
    cyc(1);
  endtask

  task automatic push_word(input string tag, input logic [19:0] w);
    push_exp(tag, w[18:10], w[3:0], w[9:4], w[19], b_enh);
  endtask

  // which: 0 m_lo, 1 m_hi, 2 ar, 3 enh, 4 hop
  task automatic pulse(input int which, input logic [7:0] d);
    pbus = d;
    cyc(4);
    case (which)
      0: stb_m_lo = 1'b1;
      1: stb_m_hi = 1'b1;
      2: stb_ar   = 1'b1;
      3: enh_wr   = 1'b1;
      default: hop_stb = 1'b1;
    endcase
    cyc(4);
    stb_m_lo = 1'b0; stb_m_hi = 1'b0; stb_ar = 1'b0; hop_stb = 1'b0;
    if (which == 3) enh_wr = 1'b0;
    cyc(4);
  endtask

  task automatic sbit(input logic b);
    sh_data = b;
    cyc(3);
    sh_clk = 1'b1;
    cyc(3);
    sh_clk = 1'b0;
    cyc(2);
  endtask

  function automatic logic [19:0] m_lo_upd(input logic [19:0] w, input logic [7:0] d);
    logic [19:0] n = w;
    n[19] = d[7]; n[16:10] = d[6:0];
    return n;
  endfunction

  function automatic logic [19:0] m_hi_upd(input logic [19:0] w, input logic [7:0] d);
    logic [19:0] n = w;
    n[9] = d[3]; n[8] = d[2]; n[18] = d[1]; n[17] = d[0];
    return n;
  endfunction

  function automatic logic [19:0] ar_upd(input logic [19:0] w, input logic [7:0] d);
    logic [19:0] n = w;
    n[7:4] = d[7:4]; n[3:0] = d[3:0];
    return n;
  endfunction

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] sword;
    rst_n = 1'b0;
    mode_direct = 0; mode_serial = 0;
    sh_clk = 0; sh_data = 0; enh_wr = 0; pbus = 8'h00;
    stb_m_lo = 0; stb_m_hi = 0; stb_ar = 0; hop_stb = 0;
    sel_pri_ser = 1; sel_pri_par = 1;
    dir_m = 9'h000; dir_a = 4'h0; dir_presc_n = 1'b0;
    b_pri = '0; b_sec = '0; b_enh = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    push_word("R1 reset state", b_pri);

    // parallel field strobes
    pulse(0, 8'hA5); b_pri = m_lo_upd(b_pri, 8'hA5);
    push_word("R5 m_lo strobe", b_pri);
    pulse(1, 8'h0B); b_pri = m_hi_upd(b_pri, 8'h0B);
    push_word("R6 m_hi strobe", b_pri);
    pulse(2, 8'h9C); b_pri = ar_upd(b_pri, 8'h9C);
    push_word("R7 ar strobe", b_pri);
    pulse(3, 8'h3C); b_enh = 8'h3C;
    push_word("R8 enh strobe", b_pri);

    // strobe held high: only the rising edge loads
    pbus = 8'h01; cyc(4);
    stb_m_lo = 1'b1; cyc(5);
    pbus = 8'hFE; cyc(8);
    stb_m_lo = 1'b0; cyc(4);
    b_pri = m_lo_upd(b_pri, 8'h01);
    push_word("R12 held strobe", b_pri);

    // hop and select in parallel mode
    pulse(4, 8'h00); b_sec = b_pri;
    pulse(2, 8'h00); b_pri = ar_upd(b_pri, 8'h00);
    push_word("R9 primary after hop", b_pri);
    sel_pri_par = 1'b0;
    push_word("R9 secondary held", b_sec);
    sel_pri_par = 1'b1; sel_pri_ser = 1'b0;
    push_word("R10 serial select ignored in parallel", b_pri);
    sel_pri_ser = 1'b1;

    // serial mode
    mode_serial = 1'b1; cyc(4);
    sword = 20'hABCDE;
    for (int i = 19; i >= 0; i--) sbit(sword[i]);
    b_pri = sword;
    push_word("R3 serial primary load", b_pri);
    pulse(0, 8'hFF);
    pulse(2, 8'hFF);
    push_word("R11 parallel strobes ignored in serial", b_pri);
    enh_wr = 1'b1; cyc(4);
    for (int i = 7; i >= 0; i--) sbit(8'hC3 >> i);
    enh_wr = 1'b0; cyc(4);
    b_enh = 8'hC3;
    push_word("R4 serial enhancement load", b_pri);
    sel_pri_ser = 1'b0;
    push_word("R10 serial select shows secondary", b_sec);
    pulse(4, 8'h00); b_sec = b_pri;
    push_word("R9 hop in serial mode", b_sec);
    sel_pri_ser = 1'b1;

    // back to parallel: shift clock ignored
    mode_serial = 1'b0; cyc(4);
    for (int i = 0; i < 6; i++) sbit(1'b1);
    push_word("R11 shift clock ignored in parallel", b_pri);
    pulse(2, 8'h5A); b_pri = ar_upd(b_pri, 8'h5A);
    push_word("R7 ar strobe second pattern", b_pri);

    // direct mode
    dir_m = 9'h155; dir_a = 4'h6; dir_presc_n = 1'b1;
    mode_direct = 1'b1; cyc(4);
    push_exp("R2 direct pins", 9'h155, 4'h6, 6'h00, 1'b1, b_enh);
    dir_m = 9'h0AA; dir_a = 4'h9; dir_presc_n = 1'b0; mode_serial = 1'b1;
    push_exp("R2 direct wins over serial", 9'h0AA, 4'h9, 6'h00, 1'b0, b_enh);
    pulse(4, 8'h00);
    pulse(3, 8'h77);
    mode_direct = 1'b0; mode_serial = 1'b0; sel_pri_par = 1'b0; cyc(4);
    push_word("R11 hop ignored in direct", b_sec);
    sel_pri_par = 1'b1;
    push_word("R11 primary kept in direct", b_pri);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule